// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised register (eight bits by default) that on each rising clock edge either keeps its value, shifts one place in either direction with a serial bit entering at the vacated end, or captures a full parallel word. Two select inputs choose the operation. An active-low clear empties the register at once, with no clock needed.

Parallel data enters and leaves through one shared tri-state bus. Inside the chip this bus is modelled as a separate input vector, an output vector and a single drive-enable bit. The bus is driven only when both active-low enables are low and the register is not loading. Loading needs the bus to act as an input, so the drive is released whenever a load is selected. The enables control the drivers only. The register keeps shifting, loading and clearing whatever the enables are set to. The two end bits are always visible on dedicated serial outputs, so the register contents can still be watched or cascaded while the bus is released.

Top module: `usr_bidir_shifter`

## Requirements
- R1: With sel = 2'b00 (hold), a rising clock edge leaves every register bit unchanged.
- R2: With sel = 2'b01 (shift toward the H end), on a rising edge bit i takes the old bit i-1, bit 0 (the A end) takes ser_r_in, and the old top bit is discarded.
- R3: With sel = 2'b10 (shift toward the A end), on a rising edge bit i takes the old bit i+1, bit WIDTH-1 (the H end) takes ser_l_in, and the old bit 0 is discarded.
- R4: With sel = 2'b11 (load), on a rising edge the register takes the value of par_in.
- R5: Driving clr_n low sets every register bit to 0 immediately, with no clock edge.
- R6: While clr_n is low, rising clock edges leave the register at 0. After clr_n goes high, the first rising edge performs the selected operation.
- R7: par_oe is 1 exactly when oe1_n = 0, oe2_n = 0 and sel is not 2'b11.
- R8: The enable inputs have no effect on the register. With the bus released by either enable, shifting and loading continue, and the results appear on par_out, end_a_out and end_h_out.
- R9: end_a_out always equals register bit 0 and end_h_out always equals register bit WIDTH-1, whatever the enables are.
- R10: par_out always presents the current register contents (bit 0 = A end).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Operation select: 00 hold, 01 shift to H end, 10 shift to A end, 11 load |
| ser_r_in | input | 1 | Serial bit entering bit 0 when shifting toward the H end |
| ser_l_in | input | 1 | Serial bit entering bit WIDTH-1 when shifting toward the A end |
| oe1_n | input | 1 | Bus drive enable, active low |
| oe2_n | input | 1 | Bus drive enable, active low |
| par_in | input | WIDTH | Value sampled from the shared bus |
| par_out | output | WIDTH | Register value offered to the shared bus |
| par_oe | output | 1 | Drive enable for the shared bus |
| end_a_out | output | 1 | Register bit 0, always driven |
| end_h_out | output | 1 | Register bit WIDTH-1, always driven |

## Verification
The clocked properties assume that sel, the serial inputs, par_in and the enables are settled and known at each rising edge. They also assume that clr_n never changes at a rising edge, because a release at an edge would make it unclear whether that edge counts. To meet these assumptions, the bench changes every input only on falling edges or a short delay after them, including the assertion and release of the clear. A reference model then predicts the register value one edge at a time and compares it with the outputs halfway through each cycle.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       oe1_n,
  input  logic       oe2_n,
  output mode_e      mode,
  output logic       port_drive
);
  logic enables_on;

  always_comb begin
    unique case (sel)
      2'b01:   mode = MODE_SHR;
      2'b10:   mode = MODE_SHL;
      2'b11:   mode = MODE_LOAD;
      default: mode = MODE_HOLD;
    endcase
  end

  // the bus is released during a load so that it can carry the incoming word
  assign enables_on = ~oe1_n & ~oe2_n;
  assign port_drive = enables_on & (mode != MODE_LOAD);
endmodule

// File: rtl/usr_shift_core.sv
module usr_shift_core
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  mode_e            mode,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  // next-state selection
  always_comb begin
    q_en  = 1'b1;
    q_nxt = q;
    unique case (mode)
      MODE_SHR:  q_nxt = {q[TOP-1:0], ser_r};
      MODE_SHL:  q_nxt = {ser_l, q[TOP:1]};
      MODE_LOAD: q_nxt = load_val;
      default:   q_en  = 1'b0;
    endcase
  end

  // state register, clear acts without the clock
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_HOLD) |=> $stable(q));

  p_shr_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_SHR) |=> (q[0] == $past(ser_r)) && (q[TOP:1] == $past(q[TOP-1:0])));

  p_shl_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_SHL) |=> (q[TOP] == $past(ser_l)) && (q[TOP-1:0] == $past(q[TOP:1])));

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_LOAD) |=> (q == $past(load_val)));

  p_clear_r6: assert property (@(posedge clk)
    !clr_n |-> (q == '0));
endmodule

// File: rtl/usr_bidir_shifter.sv
module usr_bidir_shifter
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic             oe1_n,
  input  logic             oe2_n,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  output logic             par_oe,
  output logic             end_a_out,
  output logic             end_h_out
);
  mode_e            mode;
  logic [WIDTH-1:0] reg_q;

  usr_mode_decode u_decode (
    .sel        (sel),
    .oe1_n      (oe1_n),
    .oe2_n      (oe2_n),
    .mode       (mode),
    .port_drive (par_oe)
  );

  usr_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .clr_n    (clr_n),
    .mode     (mode),
    .ser_r    (ser_r_in),
    .ser_l    (ser_l_in),
    .load_val (par_in),
    .q        (reg_q)
  );

  assign par_out   = reg_q;
  assign end_a_out = reg_q[0];
  assign end_h_out = reg_q[WIDTH-1];

  // a load with the bus released still captures the word
  p_quiet_load_r8: assert property (@(posedge clk) disable iff (!clr_n)
    ((oe1_n || oe2_n) && (sel == 2'b11)) |=> (par_out == $past(par_in)));

  // a released bus never hides the end bits
  p_ends_r9: assert property (@(posedge clk) disable iff (!clr_n)
    (oe1_n || oe2_n) |-> (end_a_out == par_out[0]) && (end_h_out == par_out[WIDTH-1]));
endmodule

// File: tb/tb_usr_bidir_shifter.sv
module tb_usr_bidir_shifter;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       clr_n;
  logic [1:0] sel;
  logic       ser_r_in, ser_l_in, oe1_n, oe2_n;
  logic [7:0] par_in;
  logic [7:0] par_out;
  logic       par_oe, end_a_out, end_h_out;

  int checks   = 0;
  int failures = 0;
  logic [7:0] m;   // reference register value

  usr_bidir_shifter #(.WIDTH(8)) dut (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r_in(ser_r_in), .ser_l_in(ser_l_in),
    .oe1_n(oe1_n), .oe2_n(oe2_n), .par_in(par_in), .par_out(par_out),
    .par_oe(par_oe), .end_a_out(end_a_out), .end_h_out(end_h_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string req);
    chk(par_out === m, req, int'(par_out), int'(m));
    chk(end_a_out === m[0] && end_h_out === m[7], "R9",
        int'({end_h_out, end_a_out}), int'({m[7], m[0]}));
  endtask

  // one cycle: drive at the falling edge, check enable, clock, check state
  task automatic step(input logic [1:0] s, input logic sr, input logic sl,
                      input logic [7:0] pin, input logic g1, input logic g2,
                      input string req);
    logic exp_oe;
    sel = s; ser_r_in = sr; ser_l_in = sl; par_in = pin; oe1_n = g1; oe2_n = g2;
    #1;
    exp_oe = (g1 == 1'b0) && (g2 == 1'b0) && (s != 2'b11);
    chk(par_oe === exp_oe, "R7", int'(par_oe), int'(exp_oe));
    @(posedge clk);
    case (s)
      2'b01:   m = 8'((int'(m) * 2 + int'(sr)) % 256);
      2'b10:   m = 8'(int'(m) / 2 + int'(sl) * 128);
      2'b11:   m = pin;
      default: m = m;
    endcase
    @(negedge clk);
    chk_state(req);
  endtask

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr_n = 1'b1; sel = 2'b00; ser_r_in = 0; ser_l_in = 0;
    oe1_n = 0; oe2_n = 0; par_in = 8'h00;
    #1 clr_n = 1'b0;
    m = 8'h00;
    @(negedge clk);
    chk_state("R5");
    @(negedge clk);
    clr_n = 1'b1;

    // load and hold
    step(2'b11, 0, 0, 8'hA5, 0, 0, "R4");
    step(2'b00, 1, 1, 8'h3C, 0, 0, "R1");
    step(2'b00, 0, 1, 8'hFF, 0, 0, "R1");
    // shift toward H end, top bit falls off
    step(2'b01, 1, 0, 8'h00, 0, 0, "R2");
    step(2'b01, 0, 1, 8'h00, 0, 0, "R2");
    step(2'b01, 1, 1, 8'h00, 0, 0, "R2");
    // shift toward A end
    step(2'b11, 0, 0, 8'h81, 0, 0, "R4");
    step(2'b10, 0, 1, 8'h00, 0, 0, "R3");
    step(2'b10, 0, 0, 8'h00, 0, 0, "R3");
    step(2'b10, 1, 1, 8'h00, 0, 0, "R3");

    // bus released by either enable: register keeps working
    step(2'b11, 0, 0, 8'h5A, 1, 0, "R8");
    step(2'b01, 1, 0, 8'h00, 0, 1, "R8");
    step(2'b10, 0, 1, 8'h00, 1, 1, "R8");
    step(2'b00, 0, 0, 8'h00, 1, 0, "R8");
    step(2'b00, 0, 0, 8'h00, 0, 0, "R10");

    // asynchronous clear mid-cycle
    #2;
    clr_n = 1'b0;
    m = 8'h00;
    #1;
    chk_state("R5");
    // edges under clear, with load selected
    sel = 2'b11; par_in = 8'hC3;
    @(negedge clk);
    chk_state("R6");
    @(negedge clk);
    chk_state("R6");
    clr_n = 1'b1;
    step(2'b11, 0, 0, 8'hC3, 0, 0, "R6");

    // random patterns
    for (int i = 0; i < 300; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      step(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), req_of(s));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule